// File: doc/BRIEF.md
# UART Receive Idle Time-out Detector

This block watches the receive side of a UART for silence between characters. Software uses it to find the end of a frame whose length is not known in advance. A programmable count of bit periods is held in a configuration register. Each character that the receiver finishes reloads a down-counter with that count. The counter then steps down once for every bit-period tick from the baud generator. When it reaches zero, a sticky time-out flag is set, and that flag can drive an interrupt.

A start command from software clears the flag and parks the counter. Counting resumes only when the next character arrives, so a long silence before the first character of a new frame never reports a time-out. A programmed count of zero turns detection off. The UART receiver, the baud generator and the bus logic sit outside this block.

Top module: `rx_idle_timer`

## Requirements
- R1: A character that arrives while the programmed count is 0 leaves the counter idle, and `timeout_o` stays 0 however many ticks follow.
- R2: A character that arrives while the programmed count N is non-zero loads N and starts the countdown.
- R3: The counter steps only on cycles with `bit_tick_i` high. Clock cycles without a tick never bring a time-out.
- R4: `timeout_o` rises on the clock edge that takes the N-th tick after the loading character. After N-1 ticks it is still 0.
- R5: `timeout_o` is sticky. It stays high until `clr_i` or `start_cmd_i` is seen. If an expiry and `clr_i` fall in the same cycle, the flag is set.
- R6: `irq_o` is high exactly when `timeout_o` and `irq_en_i` are both high.
- R7: `start_cmd_i` clears `timeout_o` and stops the counter. Ticks that follow give no time-out until a new character reloads the counter.
- R8: Once the count has expired, the counter stays idle. After a clear, further ticks do not set `timeout_o` again until a character arrives.
- R9: A character and a tick in the same cycle reload the counter, and the tick is not counted.
- R10: A write to the count register (`cfg_we_i` with `cfg_tov_i`) does not change a countdown in progress. The new value is used from the next character on.
- R11: After reset, the programmed count is 0, the counter is idle, and `timeout_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the time-out count register |
| cfg_tov_i | input | 16 | Time-out count, in bit periods |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| char_rcvd_i | input | 1 | One-cycle pulse per received character |
| start_cmd_i | input | 1 | Start command: clear the flag and park the counter until the next character |
| clr_i | input | 1 | Clears the time-out flag |
| irq_en_i | input | 1 | Interrupt enable |
| timeout_o | output | 1 | Sticky time-out flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench probes the counter at N-1 and N ticks. A design that is off by one would flag one bit early or one bit late. It also sends a tick in the same cycle as a character. A design that counted that tick before reloading would expire one bit short of the full count. Further cases cover a count rewritten in mid-countdown, ticks after an expiry has been cleared, ticks after a start command, and an expiry that coincides with a clear. A design that got these wrong would respectively pick up the new count too early, flag a second time, keep counting while it should be parked, or lose the time-out event.

// File: rtl/rx_idle_pkg.sv
package rx_idle_pkg;
  localparam int unsigned TOV_W = 16;
endpackage

// File: rtl/rx_idle_cfg.sv
module rx_idle_cfg #(
  parameter int unsigned W = rx_idle_pkg::TOV_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/rx_idle_cnt.sv
module rx_idle_cnt #(
  parameter int unsigned W = rx_idle_pkg::TOV_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         park_i,
  input  logic         tick_i,
  output logic         expire_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         act_q;
  logic         step;

  assign step     = tick_i && act_q && !load_i && !park_i;
  assign expire_o = step && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      // a reload wins over a tick in the same cycle
      cnt_q <= load_val_i;
      act_q <= (load_val_i != '0);
    end else if (park_i) begin
      act_q <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_idle_flag.sv
module rx_idle_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // an expiry is not lost to a clear
    else if (clr_i) flag_o <= 1'b0;
  end

  assign irq_o = flag_o & en_i;
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int unsigned TOV_W = rx_idle_pkg::TOV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [TOV_W-1:0] cfg_tov_i,
  input  logic             bit_tick_i,
  input  logic             char_rcvd_i,
  input  logic             start_cmd_i,
  input  logic             clr_i,
  input  logic             irq_en_i,
  output logic             timeout_o,
  output logic             irq_o
);
  logic [TOV_W-1:0] tov_q;
  logic             expire;

  rx_idle_cfg #(.W(TOV_W)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .d_i   (cfg_tov_i),
    .q_o   (tov_q)
  );

  rx_idle_cnt #(.W(TOV_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (char_rcvd_i),
    .load_val_i(tov_q),
    .park_i    (start_cmd_i),
    .tick_i    (bit_tick_i),
    .expire_o  (expire)
  );

  rx_idle_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (expire),
    .clr_i (clr_i | start_cmd_i),
    .en_i  (irq_en_i),
    .flag_o(timeout_o),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/rx_idle_timer_chk.sv
module rx_idle_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_tick_i,
  input logic char_rcvd_i,
  input logic start_cmd_i,
  input logic clr_i,
  input logic irq_en_i,
  input logic timeout_o,
  input logic irq_o
);
  // R3: a rise needs a tick on the edge that set it
  assert_rise_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(bit_tick_i));

  // R9: a reload cycle never produces an expiry
  assert_reload_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> !$past(char_rcvd_i));

  // R5: the flag holds until it is cleared
  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o && !clr_i && !start_cmd_i |=> timeout_o);

  // R5: a clear with no tick in the same cycle drops the flag
  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !bit_tick_i |=> !timeout_o);

  // R7: the start command clears the flag
  assert_start_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_cmd_i |=> !timeout_o);

  // R6: the interrupt needs both the flag and the enable
  assert_irq_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> timeout_o && irq_en_i);
endmodule

bind rx_idle_timer rx_idle_timer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_tick_i (bit_tick_i),
  .char_rcvd_i(char_rcvd_i),
  .start_cmd_i(start_cmd_i),
  .clr_i      (clr_i),
  .irq_en_i   (irq_en_i),
  .timeout_o  (timeout_o),
  .irq_o      (irq_o)
);

// File: tb/rx_idle_timer_test.sv
module rx_idle_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_tov_i = '0;
  logic        bit_tick_i = 1'b0;
  logic        char_rcvd_i = 1'b0;
  logic        start_cmd_i = 1'b0;
  logic        clr_i = 1'b0;
  logic        irq_en_i = 1'b0;
  logic        timeout_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  rx_idle_timer uut (.*);

  // vector: {count[31:16], ticks[15:1], expected flag[0]}
  localparam int NV = 7;
  localparam logic [31:0] VEC [NV] = '{
    {16'd5, 15'd4,  1'b0},
    {16'd5, 15'd5,  1'b1},
    {16'd1, 15'd1,  1'b1},
    {16'd0, 15'd20, 1'b0},
    {16'd3, 15'd10, 1'b1},
    {16'd2, 15'd1,  1'b0},
    {16'd9, 15'd9,  1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic prog(input logic [15:0] v);
    cfg_tov_i = v; cfg_we_i = 1'b1; cyc(); cfg_we_i = 1'b0;
  endtask

  task automatic chr();
    char_rcvd_i = 1'b1; cyc(); char_rcvd_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick_i = 1'b1; cyc(); bit_tick_i = 1'b0; cyc();
    end
  endtask

  task automatic clr();
    clr_i = 1'b1; cyc(); clr_i = 1'b0;
  endtask

  task automatic start();
    start_cmd_i = 1'b1; cyc(); start_cmd_i = 1'b0;
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    check("R11 flag", timeout_o, 1'b0);
    check("R11 irq", irq_o, 1'b0);
    rst_ni = 1'b1; cyc();
    chr(); ticks(5);
    check("R11 reset count 0 no timeout", timeout_o, 1'b0);

    for (int v = 0; v < NV; v++) begin
      prog(VEC[v][31:16]);
      chr();
      ticks(int'(VEC[v][15:1]));
      check("R2/R4 vector", timeout_o, VEC[v][0]);
      if (VEC[v][31:16] == 16'd0) check("R1 zero count", timeout_o, 1'b0);
      clr(); start();
    end

    // R3: clock cycles without ticks
    prog(16'd2); chr();
    repeat (50) cyc();
    check("R3 no tick no timeout", timeout_o, 1'b0);
    ticks(2);
    check("R3 ticks counted", timeout_o, 1'b1);

    // R6: interrupt enable
    check("R6 irq off", irq_o, 1'b0);
    irq_en_i = 1'b1; cyc();
    check("R6 irq on", irq_o, 1'b1);

    // R5: sticky
    ticks(3); repeat (10) cyc();
    check("R5 sticky", timeout_o, 1'b1);
    clr();
    check("R5 clear", timeout_o, 1'b0);
    check("R6 irq follows clear", irq_o, 1'b0);

    // R8: no re-set after expiry without a character
    ticks(6);
    check("R8 idle after expiry", timeout_o, 1'b0);

    // R7: start parks the counter, clears flag
    prog(16'd2); chr(); ticks(2);
    check("R7 pre", timeout_o, 1'b1);
    start();
    check("R7 start clears", timeout_o, 1'b0);
    chr(); ticks(1); start(); ticks(5);
    check("R7 parked", timeout_o, 1'b0);
    chr(); ticks(2);
    check("R7 resumes on char", timeout_o, 1'b1);
    clr();

    // R9: char and tick together
    prog(16'd3); chr(); ticks(2);
    char_rcvd_i = 1'b1; bit_tick_i = 1'b1; cyc();
    char_rcvd_i = 1'b0; bit_tick_i = 1'b0; cyc();
    ticks(2);
    check("R9 reload wins", timeout_o, 1'b0);
    ticks(1);
    check("R9 full count", timeout_o, 1'b1);
    clr();

    // R10: rewrite mid-count
    prog(16'd3); chr(); ticks(1);
    prog(16'd10); ticks(2);
    check("R10 old count used", timeout_o, 1'b1);
    clr(); chr(); ticks(9);
    check("R10 new count pending", timeout_o, 1'b0);
    ticks(1);
    check("R10 new count used", timeout_o, 1'b1);
    clr();

    // R5: expiry coincides with clear
    prog(16'd1); chr();
    bit_tick_i = 1'b1; clr_i = 1'b1; cyc();
    bit_tick_i = 1'b0; clr_i = 1'b0; cyc();
    check("R5 set beats clear", timeout_o, 1'b1);
    clr();

    // R1: count rewritten to zero, next char disables
    prog(16'd0); chr(); ticks(12);
    check("R1 disabled", timeout_o, 1'b0);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule